// File: doc/BRIEF.md
# Indirect Peripheral Access Bridge

This block lets a host with a 32-bit register interface reach two slow byte-wide peripheral chips through one command/status word. The host writes a command into the access register at byte offset 0x200 of its window. The command either loads a register address for one of the two target groups or moves one data byte to or from the address already loaded for that group. The bridge then runs a timed peripheral cycle with three phases. In the setup phase it drives address and chip select. In the strobe phase it asserts the address-latch, write or read strobe. In the hold phase it keeps the bus steady. A pending flag in the same word stays set for the whole cycle. When a read completes, the fetched byte appears in the low byte of that word.

Each group keeps its own 8-bit address latch. A software driver therefore loads an address once and then issues data commands to that group. It polls the pending flag between commands. Interrupt requests from either peripheral are held in sticky status bits that drive the host interrupt line. They stay set until the host writes the clear value to offset 0x3C.

Top module: `periph_bridge`

## Requirements
- R1: After a synchronous active-low reset the following hold: pending flag 0, returned byte 0, both group address latches 0, all chip selects and strobes inactive (per_cs_n = 2'b11, per_ale = 0, per_wr_n = 1, per_rd_n = 1, per_doe = 0), interrupt status 0 and host_irq 0.
- R2: A command accepted at a clock edge sets the pending flag (bit 25 of the access word). The flag reads 1 for SETUP_CYC + STROBE_CYC + HOLD_CYC cycles and reads 0 from the following edge on.
- R3: A write to offset 0x200 with bit 23 = 1 and bit 16 = 0 stores bits 7:0 in the address latch of the group chosen by bit 20. Its cycle asserts that group's chip select, puts the byte on per_dout with per_doe = 1, and raises per_ale during the strobe phase.
- R4: A write to offset 0x200 with bit 23 = 1 and bit 16 = 1 drives the chosen group's latched address on per_addr and bits 7:0 on per_dout with per_doe = 1. It pulls per_wr_n low for STROBE_CYC cycles, starting SETUP_CYC cycles after acceptance.
- R5: A write to offset 0x200 with bit 23 = 0 and bit 16 = 1 is a read. It pulls per_rd_n low with per_doe = 0 and samples per_din at the last strobe cycle. Once the pending flag clears, bits 7:0 of the access word hold that byte. Writes and address loads leave the returned byte unchanged.
- R6: Bit 20 selects group 0 (per_cs_n = 2'b10) or group 1 (per_cs_n = 2'b01) for the whole cycle. An address loaded for one group never alters the other group's latch.
- R7: A command written while the pending flag is 1 is ignored. It changes no latch, does not extend or restart the running cycle, and starts no new cycle.
- R8: A write to offset 0x200 with bit 23 = 0 and bit 16 = 0 starts no cycle. A write to any offset other than 0x200 starts no cycle.
- R9: A high level on either per_irq bit sets the matching sticky status bit. Reading offset 0x3C returns those bits in bits 1:0. host_irq is the OR of them. A write to offset 0x3C with bits 30:28 all 1 (for example 0x70000000) clears them, and any other value written there does not.
- R10: When an interrupt input is high in the same cycle as a clearing write, that status bit stays set.
- R11: The access word reads with only bit 25 (pending) and bits 7:0 (returned byte) possibly nonzero. All other offsets except 0x3C read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | AW | Host byte offset for both reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| host_irq | output | 1 | Host interrupt, OR of sticky status bits |
| per_cs_n | output | 2 | Active-low chip selects, one per group |
| per_addr | output | 8 | Latched register address of the active group |
| per_dout | output | 8 | Byte driven toward the peripheral |
| per_doe | output | 1 | Output enable for per_dout |
| per_din | input | 8 | Byte returned by the peripheral |
| per_ale | output | 1 | Address-latch strobe, active high |
| per_wr_n | output | 1 | Write strobe, active low |
| per_rd_n | output | 1 | Read strobe, active low |
| per_irq | input | 2 | Interrupt requests from the two peripherals |

## Verification
Two pairs of events can fall in the same cycle. The first is a new command arriving while a cycle is running. The second is an interrupt input rising in the same cycle as a clearing write to offset 0x3C. The bench writes a second access command two cycles into a running read. It then judges that the cycle length, the returned byte and the group's address latch (observed on per_addr in a later cycle) are all untouched. For the second pair, it holds one per_irq bit high in exactly the cycle of the clearing write. It then judges from host_irq and the 0x3C read that the bit survived while the clear still took effect on the other bit.

// File: rtl/pb_pkg.sv
// Shared constants and types for the indirect peripheral access bridge.
// Assumes host offsets are byte offsets of at least 10 bits.
package pb_pkg;
    localparam int ACC_OFS   = 'h200;   // access (command/status) word
    localparam int IRQ_OFS   = 'h03C;   // interrupt status / clear word
    localparam int BIT_PEND  = 25;
    localparam int BIT_WRITE = 23;
    localparam int BIT_GRP   = 20;
    localparam int BIT_SUB   = 16;
    localparam int NGRP      = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_t;

    typedef struct packed {
        op_t        op;
        logic       grp;
        logic [7:0] val;
    } cmd_t;
endpackage

// File: rtl/pb_cmd_decode.sv
// Decodes host writes into a peripheral command and an interrupt clear.
// Assumes a host write lasts exactly one cycle; purely combinational.
module pb_cmd_decode
    import pb_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output cmd_t          cmd,
    output logic          cmd_valid,
    output logic          irq_clr
);
    logic hit_acc;

    // Classify the command word by its write and sub-register bits.
    always_comb begin
        hit_acc = we && (addr == AW'(ACC_OFS));
        cmd.grp = wdata[BIT_GRP];
        cmd.val = wdata[7:0];
        unique case ({wdata[BIT_WRITE], wdata[BIT_SUB]})
            2'b10:   cmd.op = OP_ADDR;
            2'b11:   cmd.op = OP_WRITE;
            2'b01:   cmd.op = OP_READ;
            default: cmd.op = OP_NONE;
        endcase
        cmd_valid = hit_acc && (cmd.op != OP_NONE);
        irq_clr   = we && (addr == AW'(IRQ_OFS)) && (&wdata[30:28]);
    end
endmodule

// File: rtl/pb_strobe_seq.sv
// Timed setup / strobe / hold sequencer for one peripheral cycle.
// Assumes every phase length is at least one cycle; start is ignored when busy.
module pb_strobe_seq
    import pb_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_t phase,
    output logic   busy,
    output logic   sample
);
    localparam int MAXC = (SETUP_CYC > STROBE_CYC)
                        ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                        : ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
    localparam int CW = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    // Advance through the phases, counting cycles inside each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) phase <= PH_SETUP;
                end
                PH_SETUP: begin
                    if (cnt == CW'(SETUP_CYC - 1)) begin
                        phase <= PH_STROBE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_STROBE: begin
                    if (cnt == CW'(STROBE_CYC - 1)) begin
                        phase <= PH_HOLD;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: begin
                    if (cnt == CW'(HOLD_CYC - 1)) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // Busy spans all non-idle phases; sample marks the last strobe cycle.
    always_comb begin
        busy   = (phase != PH_IDLE);
        sample = (phase == PH_STROBE) && (cnt == CW'(STROBE_CYC - 1));
    end
endmodule

// File: rtl/pb_irq_latch.sv
// Sticky interrupt status, one bit per peripheral; set has priority over clear.
// Assumes interrupt inputs are already synchronous to clk.
module pb_irq_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic         clr,
    output logic [N-1:0] status
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold each request until a clear arrives with no new request.
        always_ff @(posedge clk) begin
            if (!rst_n)         status[i] <= 1'b0;
            else if (irq_in[i]) status[i] <= 1'b1;
            else if (clr)       status[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/periph_bridge.sv
// Indirect peripheral access bridge: one host command/status word drives
// address-load, data-write and data-read cycles on a byte bus to two groups.
// Assumes the host polls the pending flag; commands during a cycle are dropped.
module periph_bridge
    import pb_pkg::*;
#(
    parameter int AW         = 12,
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    output logic          host_irq,
    output logic [1:0]    per_cs_n,
    output logic [7:0]    per_addr,
    output logic [7:0]    per_dout,
    output logic          per_doe,
    input  logic [7:0]    per_din,
    output logic          per_ale,
    output logic          per_wr_n,
    output logic          per_rd_n,
    input  logic [1:0]    per_irq
);
    cmd_t       cmd;
    logic       cmd_valid, irq_clr, accept;
    phase_t     phase;
    logic       busy, sample, strobe;
    logic [1:0] irq_status;
    op_t        act_op;
    logic       act_grp;
    logic [7:0] act_val;
    logic [7:0] rd_byte;
    logic [7:0] addr_lat [NGRP];

    pb_cmd_decode #(.AW(AW)) u_dec (
        .we        (host_we),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .cmd       (cmd),
        .cmd_valid (cmd_valid),
        .irq_clr   (irq_clr)
    );

    pb_strobe_seq #(
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .phase  (phase),
        .busy   (busy),
        .sample (sample)
    );

    pb_irq_latch #(.N(NGRP)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (per_irq),
        .clr    (irq_clr),
        .status (irq_status)
    );

    assign accept = cmd_valid && !busy;
    assign strobe = (phase == PH_STROBE);

    // Per-group address latches, loaded only by an accepted address command.
    for (genvar g = 0; g < NGRP; g++) begin : g_lat
        always_ff @(posedge clk) begin
            if (!rst_n)
                addr_lat[g] <= '0;
            else if (accept && cmd.op == OP_ADDR && cmd.grp == 1'(g))
                addr_lat[g] <= cmd.val;
        end
        // Chip select follows the active group for the whole cycle.
        assign per_cs_n[g] = !(busy && act_grp == 1'(g));
    end

    // Capture the accepted command for the duration of its cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_op  <= OP_NONE;
            act_grp <= 1'b0;
            act_val <= '0;
        end else if (accept) begin
            act_op  <= cmd.op;
            act_grp <= cmd.grp;
            act_val <= cmd.val;
        end
    end

    // Take the peripheral byte at the last strobe cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rd_byte <= '0;
        else if (sample && act_op == OP_READ) rd_byte <= per_din;
    end

    // Peripheral bus outputs derived from the phase and the active command.
    always_comb begin
        per_addr = addr_lat[act_grp];
        per_dout = act_val;
        per_doe  = busy && (act_op == OP_ADDR || act_op == OP_WRITE);
        per_ale  = strobe && (act_op == OP_ADDR);
        per_wr_n = !(strobe && (act_op == OP_WRITE));
        per_rd_n = !(strobe && (act_op == OP_READ));
    end

    // Host read mux and interrupt output.
    always_comb begin
        if (host_addr == AW'(ACC_OFS))
            host_rdata = {6'b0, busy, 17'b0, rd_byte};
        else if (host_addr == AW'(IRQ_OFS))
            host_rdata = {30'b0, irq_status};
        else
            host_rdata = '0;
        host_irq = |irq_status;
    end
endmodule

// File: rtl/pb_bridge_chk.sv
// Assertion checker for periph_bridge, attached by bind below.
// Assumes the same parameters as the bound bridge instance.
module pb_bridge_chk
    import pb_pkg::*;
#(
    parameter int AW         = 12,
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          host_we,
    input logic [AW-1:0] host_addr,
    input logic [31:0]   host_wdata,
    input logic          host_irq,
    input logic [1:0]    per_cs_n,
    input logic [7:0]    per_addr,
    input logic [7:0]    per_dout,
    input logic          per_doe,
    input logic          per_ale,
    input logic          per_wr_n,
    input logic          per_rd_n,
    input logic [1:0]    per_irq
);
    localparam int TOTAL = SETUP_CYC + STROBE_CYC + HOLD_CYC;

    logic [15:0] run_len;
    logic        clr_wr;

    // Count the cycles the pending flag has been high.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    assign clr_wr = host_we && (host_addr == AW'(IRQ_OFS)) && (&host_wdata[30:28]);

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_len != 0) |-> (run_len == 16'(TOTAL)))
        else $error("pending length"); // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({per_ale, !per_wr_n, !per_rd_n}))
        else $error("strobes overlap"); // R4
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~per_cs_n))
        else $error("two chip selects"); // R6
    AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (per_ale || !per_wr_n || !per_rd_n) |-> (per_cs_n != 2'b11))
        else $error("strobe without select"); // R6
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !per_rd_n |-> !per_doe)
        else $error("drive during read"); // R5
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(per_addr) && $stable(per_dout) && $stable(per_cs_n)))
        else $error("bus moved in cycle"); // R7
    AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|per_irq) |=> host_irq)
        else $error("irq not set"); // R10
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !clr_wr) |=> host_irq)
        else $error("irq dropped"); // R9
endmodule

bind periph_bridge pb_bridge_chk #(
    .AW         (AW),
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_irq   (host_irq),
    .per_cs_n   (per_cs_n),
    .per_addr   (per_addr),
    .per_dout   (per_dout),
    .per_doe    (per_doe),
    .per_ale    (per_ale),
    .per_wr_n   (per_wr_n),
    .per_rd_n   (per_rd_n),
    .per_irq    (per_irq)
);

// File: tb/periph_bridge_test.sv
module periph_bridge_test;
    localparam int AW  = 12;
    localparam int SU  = 2;
    localparam int ST  = 3;
    localparam int HD  = 1;
    localparam int N   = SU + ST + HD;
    localparam logic [AW-1:0] ACC = 12'h200;
    localparam logic [AW-1:0] IRQ = 12'h03C;

    // {command, peripheral byte, expected returned byte}
    localparam logic [47:0] VEC [9] = '{
        48'h00800012_00_00,
        48'h008100A5_00_00,
        48'h0091005A_00_00,
        48'h00900034_00_00,
        48'h00110000_C3_C3,
        48'h00010000_7E_7E,
        48'h00810011_00_7E,
        48'h00800099_00_7E,
        48'h00010000_0F_0F
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = ACC;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          host_irq;
    logic [1:0]    per_cs_n;
    logic [7:0]    per_addr, per_dout, per_din = '0;
    logic          per_doe, per_ale, per_wr_n, per_rd_n;
    logic [1:0]    per_irq = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] mdl_lat [2];

    always #10 clk = ~clk;

    periph_bridge #(.AW(AW), .SETUP_CYC(SU), .STROBE_CYC(ST), .HOLD_CYC(HD)) uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .per_cs_n(per_cs_n), .per_addr(per_addr), .per_dout(per_dout),
        .per_doe(per_doe), .per_din(per_din), .per_ale(per_ale),
        .per_wr_n(per_wr_n), .per_rd_n(per_rd_n), .per_irq(per_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_addr = ACC;
        #1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        host_addr = a;
        #1 d = host_rdata;
        host_addr = ACC;
    endtask

    task automatic idle_bus(input string req);
        chk(req, {per_cs_n, per_ale, per_wr_n, per_rd_n, per_doe}, {2'b11, 1'b0, 1'b1, 1'b1, 1'b0});
    endtask

    task automatic run_vec(input logic [47:0] v);
        logic [31:0] cmd, r;
        logic w, s, g;
        cmd = v[47:16]; w = cmd[23]; s = cmd[16]; g = cmd[20];
        per_din = v[15:8];
        if (w && !s) mdl_lat[g] = cmd[7:0];
        host_wr(ACC, cmd);
        rd(ACC, r);
        chk("R2 pending set", {31'b0, r[25]}, 32'd1);
        repeat (SU) @(negedge clk);
        #1;
        chk("R6 select", {30'b0, per_cs_n}, {30'b0, g ? 2'b01 : 2'b10});
        chk("R3/R4/R5 strobes", {29'b0, per_ale, per_wr_n, per_rd_n},
            {29'b0, w && !s, !(w && s), !(!w && s)});
        chk("R4/R5 drive", {31'b0, per_doe}, {31'b0, w});
        if (w) chk("R3/R4 data", {24'b0, per_dout}, {24'b0, cmd[7:0]});
        if (s) chk("R4/R6 latched address", {24'b0, per_addr}, {24'b0, mdl_lat[g]});
        repeat (ST + HD - 1) @(negedge clk);
        #1 rd(ACC, r);
        chk("R2 pending held", {31'b0, r[25]}, 32'd1);
        @(negedge clk);
        #1 rd(ACC, r);
        chk("R5/R11 result word", r, {24'b0, v[7:0]});
        idle_bus("R2 bus idle after cycle");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        mdl_lat[0] = 8'h00; mdl_lat[1] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd(ACC, r);  chk("R1 access word", r, 32'h0);
        rd(IRQ, r);  chk("R1 irq status", r, 32'h0);
        chk("R1 host_irq", {31'b0, host_irq}, 32'h0);
        idle_bus("R1 bus idle");

        foreach (VEC[i]) run_vec(VEC[i]);

        // R7: command during a running read is dropped
        per_din = 8'hAA;
        host_wr(ACC, 32'h0001_0000);
        host_wr(ACC, 32'h0080_0055);
        repeat (N - 3) @(negedge clk);
        #1 rd(ACC, r);
        chk("R7 cycle not restarted", {31'b0, r[25]}, 32'd1);
        @(negedge clk);
        #1 rd(ACC, r);
        chk("R7 cycle not extended", r, 32'h0000_00AA);
        host_wr(ACC, 32'h0081_0001);
        repeat (SU) @(negedge clk);
        #1 chk("R7 latch untouched", {24'b0, per_addr}, 32'h99);
        repeat (ST + HD) @(negedge clk);

        // R8: reserved command and foreign offset start nothing
        host_wr(ACC, 32'h0000_00FF);
        rd(ACC, r);
        chk("R8 no cycle for read of sub 0", r, 32'h0000_00AA);
        host_wr(12'h204, 32'h0081_00FF);
        rd(ACC, r);
        chk("R8 no cycle for other offset", {31'b0, r[25]}, 32'd0);
        repeat (SU + 1) @(negedge clk);
        #1 idle_bus("R8 bus stays idle");
        rd(12'h204, r);
        chk("R11 other offset reads 0", r, 32'h0);

        // R9: sticky interrupt and clear rules
        @(negedge clk); per_irq = 2'b10;
        @(negedge clk); per_irq = 2'b00;
        repeat (3) @(negedge clk);
        #1 chk("R9 host_irq sticky", {31'b0, host_irq}, 32'd1);
        rd(IRQ, r); chk("R9 status bits", r, 32'h2);
        host_wr(IRQ, 32'h3000_0000);
        chk("R9 partial clear ignored", {31'b0, host_irq}, 32'd1);
        host_wr(IRQ, 32'h7000_0000);
        chk("R9 clear", {31'b0, host_irq}, 32'd0);
        rd(IRQ, r); chk("R9 status cleared", r, 32'h0);

        // R10: set and clear in the same cycle
        @(negedge clk); per_irq = 2'b10;
        @(negedge clk); per_irq = 2'b00;
        @(negedge clk);
        host_we = 1'b1; host_addr = IRQ; host_wdata = 32'h7000_0000; per_irq = 2'b01;
        @(negedge clk);
        host_we = 1'b0; host_addr = ACC; per_irq = 2'b00;
        #1 rd(IRQ, r);
        chk("R10 set wins, other bit cleared", r, 32'h1);
        chk("R10 host_irq", {31'b0, host_irq}, 32'd1);
        host_wr(IRQ, 32'h7000_0000);

        // R1: reset in the middle of a cycle
        host_wr(ACC, 32'h0090_0077);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 rd(ACC, r);
        chk("R1 reset mid-cycle word", r, 32'h0);
        idle_bus("R1 reset mid-cycle bus");
        host_wr(ACC, 32'h0091_0000);
        repeat (SU) @(negedge clk);
        #1 chk("R1 group 1 latch cleared", {24'b0, per_addr}, 32'h0);
        repeat (ST + HD) @(negedge clk);
        host_wr(ACC, 32'h0081_0000);
        repeat (SU) @(negedge clk);
        #1 chk("R1 group 0 latch cleared", {24'b0, per_addr}, 32'h0);
        repeat (ST + HD + 1) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule